// File: doc/BRIEF.md
# Double-Fault Corrector for Four Parallel 4-Point FFTs

This block runs four independent 4-point complex transforms side by side and keeps their results correct when up to two of them are damaged. Three extra transform engines work on three-input sums of the original vectors: engine set {0,1,2}, set {0,1,3} and set {0,2,3}. Because the transform is linear, each extra engine's output equals the sum of its members' outputs. A damaged member can therefore be rebuilt by subtracting the healthy members from that extra output.

Each original engine has a checker made only of adders. For any 4-point transform, the four output bins sum to four times input sample 0. A mismatch in the real or the imaginary part marks that engine as faulty. With one faulty engine, the block repairs it in one stage. With two, it repairs the lower-numbered engine first, using an extra engine whose set leaves out the other faulty engine. It then repairs the second one in a further cycle, using the value it has just rebuilt.

Faults are injected through a per-engine mask. The mask is XORed into the low W bits of the real part of bin 1 of that engine's result, before the checker sees it.

Top module: `fft_pair_mender`

## Requirements
- R1: While reset is low, every output bin reads zero, `err_flags` is 0 and `done` is low.
- R2: A `start` seen in the idle state captures the inputs. With no fault, `done` is high in the cycle after the second rising edge from the sampling edge, and each bin k of engine e is the sum over n of x[n]·(−j)^(n·k). Inputs are packed with engine e, point n at slice (4e+n); outputs are W+2 bits wide and packed the same way.
- R3: Bit e of `err_flags` is set exactly when the mask for engine e is nonzero. The mask is XORed into the low W bits of bin 1 real of that engine, and detection uses the check "bin sum equals 4·x[0]".
- R4: With a single faulty engine, every output bin equals the fault-free transform, and `done` keeps the R2 timing.
- R5: With two faulty engines, every output bin equals the fault-free transform, and `done` arrives one cycle later than in R2.
- R6: Whenever at most two flags are set, the corrected output of every engine again satisfies the bin-sum check when `done` is high.
- R7: With three or four faulty engines, all flags of the faulty engines are set. The outputs carry the corrupted bins unchanged, truncated to W+2 bits, with the R2 timing.
- R8: A `start` that arrives while a run is in progress is ignored. The running result is unaffected and no extra `done` follows.
- R9: `done` is high for exactly one cycle per run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch a run when idle |
| din_re | input | 16*W | Real parts of the four input vectors |
| din_im | input | 16*W | Imaginary parts of the four input vectors |
| flt_mask | input | 4*W | Per-engine fault mask applied to bin 1 real |
| dout_re | output | 16*(W+2) | Real parts of the corrected bins |
| dout_im | output | 16*(W+2) | Imaginary parts of the corrected bins |
| err_flags | output | 4 | Per-engine fault flags of the last run |
| done | output | 1 | One-cycle result strobe |

## Verification
The assertions assume that the three extra engines are never damaged and that the captured inputs stay unchanged until `done`. The bench meets this by driving masks only into the four original engines. It also changes inputs only between runs, except in the deliberate busy-start case. The repaired-sum property further assumes that a corrupted bin never wraps back to its true value. The internal width of W+4 bits, together with masks limited to W bits, keeps every injected fault visible to the checker.

// File: rtl/fft_pair_mender.sv
module fft_pair_mender #(
  parameter int W = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [16*W-1:0]     din_re,
  input  logic [16*W-1:0]     din_im,
  input  logic [4*W-1:0]      flt_mask,
  output logic [16*(W+2)-1:0] dout_re,
  output logic [16*(W+2)-1:0] dout_im,
  output logic [3:0]          err_flags,
  output logic                done
);
  localparam int NE = 4, NP = 4, NR = 3;
  localparam int DW = W + 2, EW = W + 4, CW = W + 6;
  localparam logic [NE-1:0] EQ_SET [NR] = '{4'b0111, 4'b1011, 4'b1101};

  typedef enum logic [1:0] {S_IDLE, S_FIX1, S_FIX2} st_t;
  st_t st;

  logic signed [W-1:0]  xr_q [NE][NP];
  logic signed [W-1:0]  xi_q [NE][NP];
  logic [W-1:0]         mask_q [NE];
  logic signed [EW-1:0] er [NE+NR][NP];
  logic signed [EW-1:0] ei [NE+NR][NP];
  logic signed [EW-1:0] fr [NE+NR][NP];
  logic signed [EW-1:0] fi [NE+NR][NP];
  logic signed [EW-1:0] br [NE][NP];
  logic signed [EW-1:0] bi [NE][NP];
  logic signed [EW-1:0] yr_q [NE][NP];
  logic signed [EW-1:0] yi_q [NE][NP];
  logic signed [EW-1:0] sr [NE][NP];
  logic signed [EW-1:0] si [NE][NP];
  logic signed [EW-1:0] fix_r [NP];
  logic signed [EW-1:0] fix_i [NP];
  logic signed [CW-1:0] acc_r, acc_i, ref_r, ref_i;
  logic [NE-1:0] err, pend_q;
  logic [1:0]    tgt, eqs;
  logic [2:0]    nerr;

  function automatic logic [1:0] lowbit(input logic [NE-1:0] v);
    lowbit = 2'd0;
    for (int i = NE - 1; i >= 0; i--) if (v[i]) lowbit = 2'(i);
  endfunction

  function automatic logic [1:0] pick_eq(input logic [1:0] t, input logic [NE-1:0] bad);
    pick_eq = 2'd0;
    for (int r = NR - 1; r >= 0; r--)
      if (EQ_SET[r][t] && ((EQ_SET[r] & bad & ~(NE'(1) << t)) == '0)) pick_eq = 2'(r);
  endfunction

  always_comb begin
    for (int e = 0; e < NE; e++)
      for (int n = 0; n < NP; n++) begin
        er[e][n] = EW'(xr_q[e][n]);
        ei[e][n] = EW'(xi_q[e][n]);
      end
    for (int r = 0; r < NR; r++)
      for (int n = 0; n < NP; n++) begin
        er[NE+r][n] = '0;
        ei[NE+r][n] = '0;
        for (int e = 0; e < NE; e++)
          if (EQ_SET[r][e]) begin
            er[NE+r][n] = er[NE+r][n] + EW'(xr_q[e][n]);
            ei[NE+r][n] = ei[NE+r][n] + EW'(xi_q[e][n]);
          end
      end
  end

  for (genvar g = 0; g < NE + NR; g++) begin : g_eng
    logic signed [EW-1:0] d0r, d0i, d1r, d1i;
    assign d0r = er[g][0] - er[g][2];
    assign d0i = ei[g][0] - ei[g][2];
    assign d1r = er[g][1] - er[g][3];
    assign d1i = ei[g][1] - ei[g][3];
    assign fr[g][0] = er[g][0] + er[g][1] + er[g][2] + er[g][3];
    assign fi[g][0] = ei[g][0] + ei[g][1] + ei[g][2] + ei[g][3];
    assign fr[g][2] = er[g][0] - er[g][1] + er[g][2] - er[g][3];
    assign fi[g][2] = ei[g][0] - ei[g][1] + ei[g][2] - ei[g][3];
    assign fr[g][1] = d0r + d1i;
    assign fi[g][1] = d0i - d1r;
    assign fr[g][3] = d0r - d1i;
    assign fi[g][3] = d0i + d1r;
  end

  always_comb begin
    acc_r = '0; acc_i = '0; ref_r = '0; ref_i = '0;
    for (int e = 0; e < NE; e++) begin
      for (int n = 0; n < NP; n++) begin
        br[e][n] = (n == 1) ? (fr[e][n] ^ EW'(mask_q[e])) : fr[e][n];
        bi[e][n] = fi[e][n];
      end
      acc_r = CW'(br[e][0]) + CW'(br[e][1]) + CW'(br[e][2]) + CW'(br[e][3]);
      acc_i = CW'(bi[e][0]) + CW'(bi[e][1]) + CW'(bi[e][2]) + CW'(bi[e][3]);
      ref_r = CW'(xr_q[e][0]) <<< 2;
      ref_i = CW'(xi_q[e][0]) <<< 2;
      err[e] = (acc_r != ref_r) || (acc_i != ref_i);
    end
  end

  assign nerr = 3'($countones(err));

  always_comb begin
    if (st == S_FIX2) begin
      tgt = lowbit(pend_q);
      eqs = pick_eq(tgt, pend_q);
      sr  = yr_q;
      si  = yi_q;
    end else begin
      tgt = lowbit(err);
      eqs = pick_eq(tgt, err);
      sr  = br;
      si  = bi;
    end
    for (int n = 0; n < NP; n++) begin
      fix_r[n] = fr[NE+int'(eqs)][n];
      fix_i[n] = fi[NE+int'(eqs)][n];
      for (int e = 0; e < NE; e++)
        if (EQ_SET[eqs][e] && (e != int'(tgt))) begin
          fix_r[n] = fix_r[n] - sr[e][n];
          fix_i[n] = fix_i[n] - si[e][n];
        end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      done <= 1'b0;
      err_flags <= '0;
      pend_q <= '0;
      for (int e = 0; e < NE; e++) begin
        mask_q[e] <= '0;
        for (int n = 0; n < NP; n++) begin
          xr_q[e][n] <= '0;
          xi_q[e][n] <= '0;
          yr_q[e][n] <= '0;
          yi_q[e][n] <= '0;
        end
      end
    end else begin
      done <= 1'b0;
      unique case (st)
        S_IDLE: if (start) begin
          for (int e = 0; e < NE; e++) begin
            mask_q[e] <= flt_mask[e*W +: W];
            for (int n = 0; n < NP; n++) begin
              xr_q[e][n] <= din_re[(e*NP+n)*W +: W];
              xi_q[e][n] <= din_im[(e*NP+n)*W +: W];
            end
          end
          st <= S_FIX1;
        end
        S_FIX1: begin
          err_flags <= err;
          for (int e = 0; e < NE; e++)
            for (int n = 0; n < NP; n++)
              if ((nerr == 3'd1 || nerr == 3'd2) && e == int'(tgt)) begin
                yr_q[e][n] <= fix_r[n];
                yi_q[e][n] <= fix_i[n];
              end else begin
                yr_q[e][n] <= br[e][n];
                yi_q[e][n] <= bi[e][n];
              end
          if (nerr == 3'd2) begin
            pend_q <= err & ~(NE'(1) << tgt);
            st <= S_FIX2;
          end else begin
            done <= 1'b1;
            st <= S_IDLE;
          end
        end
        S_FIX2: begin
          for (int n = 0; n < NP; n++) begin
            yr_q[tgt][n] <= fix_r[n];
            yi_q[tgt][n] <= fix_i[n];
          end
          done <= 1'b1;
          st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_comb
    for (int e = 0; e < NE; e++)
      for (int n = 0; n < NP; n++) begin
        dout_re[(e*NP+n)*DW +: DW] = yr_q[e][n][DW-1:0];
        dout_im[(e*NP+n)*DW +: DW] = yi_q[e][n][DW-1:0];
      end

  logic [NE-1:0] ychk;
  logic signed [CW-1:0] ys_r, ys_i;
  always_comb begin
    ys_r = '0; ys_i = '0;
    for (int e = 0; e < NE; e++) begin
      ys_r = CW'(yr_q[e][0]) + CW'(yr_q[e][1]) + CW'(yr_q[e][2]) + CW'(yr_q[e][3]);
      ys_i = CW'(yi_q[e][0]) + CW'(yi_q[e][1]) + CW'(yi_q[e][2]) + CW'(yi_q[e][3]);
      ychk[e] = (ys_r == (CW'(xr_q[e][0]) <<< 2)) && (ys_i == (CW'(xi_q[e][0]) <<< 2));
    end
  end

  p_start_launch_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && start) |=> (st == S_FIX1));
  p_second_stage_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_FIX2) |=> done);
  p_pending_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_FIX2) |-> ($countones(pend_q) == 1));
  p_repaired_sums_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && $countones(err_flags) <= 2) |-> (ychk == '1));
  p_busy_start_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st != S_IDLE && start) |=> (st != S_FIX1));
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: tb/test_fft_pair_mender.sv
module test_fft_pair_mender;
  localparam int W = 12, DW = W + 2, EW = W + 4;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [16*W-1:0] din_re = '0, din_im = '0;
  logic [4*W-1:0] flt_mask = '0;
  logic [16*DW-1:0] dout_re, dout_im;
  logic [3:0] err_flags;
  logic done;

  fft_pair_mender #(.W(W)) i_fft_pair_mender (
    .clk(clk), .rst_n(rst_n), .start(start), .din_re(din_re), .din_im(din_im),
    .flt_mask(flt_mask), .dout_re(dout_re), .dout_im(dout_im),
    .err_flags(err_flags), .done(done));

  always #10 clk = ~clk;

  int xr [4][4];
  int xi [4][4];
  int m [4];
  int n_chk = 0, n_bad = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int nflt();
    int c = 0;
    for (int e = 0; e < 4; e++) if (m[e] != 0) c++;
    return c;
  endfunction

  function automatic int tw_c(input int p);
    case (p % 4) 0: return 1; 2: return -1; default: return 0; endcase
  endfunction
  function automatic int tw_s(input int p);
    case (p % 4) 1: return -1; 3: return 1; default: return 0; endcase
  endfunction

  function automatic logic [DW-1:0] exp_bin(input int e, input int k, input bit im);
    int ar = 0, ai = 0;
    logic [EW-1:0] v;
    for (int n = 0; n < 4; n++) begin
      ar += xr[e][n] * tw_c(n * k) - xi[e][n] * tw_s(n * k);
      ai += xr[e][n] * tw_s(n * k) + xi[e][n] * tw_c(n * k);
    end
    if (!im && k == 1 && m[e] != 0 && nflt() >= 3) begin
      v = EW'(ar) ^ EW'(m[e]);
      return v[DW-1:0];
    end
    return im ? DW'(ai) : DW'(ar);
  endfunction

  task automatic drive();
    for (int e = 0; e < 4; e++) begin
      flt_mask[e*W +: W] = W'(m[e]);
      for (int n = 0; n < 4; n++) begin
        din_re[(e*4+n)*W +: W] = W'(xr[e][n]);
        din_im[(e*4+n)*W +: W] = W'(xi[e][n]);
      end
    end
  endtask

  task automatic fill_random();
    for (int e = 0; e < 4; e++)
      for (int n = 0; n < 4; n++) begin
        xr[e][n] = int'($urandom_range(4095)) - 2048;
        xi[e][n] = int'($urandom_range(4095)) - 2048;
      end
  endtask

  task automatic check_outs(input string req);
    bit ok = 1'b1;
    int a = 0, x = 0;
    for (int e = 0; e < 4; e++)
      for (int k = 0; k < 4; k++) begin
        if (ok && dout_re[(e*4+k)*DW +: DW] != exp_bin(e, k, 1'b0)) begin
          ok = 1'b0; a = int'($signed(dout_re[(e*4+k)*DW +: DW])); x = int'($signed(exp_bin(e, k, 1'b0)));
        end
        if (ok && dout_im[(e*4+k)*DW +: DW] != exp_bin(e, k, 1'b1)) begin
          ok = 1'b0; a = int'($signed(dout_im[(e*4+k)*DW +: DW])); x = int'($signed(exp_bin(e, k, 1'b1)));
        end
      end
    chk(ok, req, "output bins", a, x);
  endtask

  task automatic launch();
    drive();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic finish_run(input string req);
    int ef = 0;
    for (int e = 0; e < 4; e++) if (m[e] != 0) ef |= (1 << e);
    @(negedge clk);
    if (nflt() == 2) begin
      chk(done == 1'b0, "R5", "done early", int'(done), 0);
      @(negedge clk);
    end
    chk(done == 1'b1, req, "done", int'(done), 1);
    chk(int'(err_flags) == ef, "R3", "err_flags", int'(err_flags), ef);
    check_outs(req);
    @(negedge clk);
    chk(done == 1'b0, "R9", "done width", int'(done), 0);
  endtask

  task automatic t_reset();
    chk(dout_re == '0 && dout_im == '0, "R1", "outputs in reset", 0, 0);
    chk(err_flags == '0, "R1", "flags in reset", int'(err_flags), 0);
    chk(done == 1'b0, "R1", "done in reset", int'(done), 0);
  endtask

  task automatic t_clean();
    for (int i = 0; i < 2; i++) begin
      fill_random();
      m = '{0, 0, 0, 0};
      launch();
      finish_run("R2");
    end
    for (int e = 0; e < 4; e++)
      for (int n = 0; n < 4; n++) begin
        xr[e][n] = -2048;
        xi[e][n] = 2047;
      end
    launch();
    finish_run("R2");
  endtask

  task automatic t_single();
    for (int f = 0; f < 4; f++) begin
      fill_random();
      m = '{0, 0, 0, 0};
      m[f] = 12'h5A3 + f;
      launch();
      finish_run("R4");
    end
  endtask

  task automatic t_pair();
    for (int a = 0; a < 4; a++)
      for (int b = a + 1; b < 4; b++) begin
        fill_random();
        m = '{0, 0, 0, 0};
        m[a] = 12'hFFF;
        m[b] = 12'h001 + a * 16 + b;
        launch();
        finish_run("R5 R6");
      end
  endtask

  task automatic t_many();
    fill_random();
    m = '{12'h0F0, 12'h333, 0, 12'h801};
    launch();
    finish_run("R7");
    fill_random();
    m = '{1, 2, 4, 8};
    launch();
    finish_run("R7");
  endtask

  task automatic t_busy();
    int sxr [4][4];
    int sxi [4][4];
    int sm [4];
    fill_random();
    m = '{0, 12'h111, 12'h222, 0};
    sxr = xr; sxi = xi; sm = m;
    launch();
    fill_random();
    m = '{0, 0, 0, 0};
    drive();
    start = 1'b1;
    xr = sxr; xi = sxi; m = sm;
    @(negedge clk);
    start = 1'b0;
    chk(done == 1'b0, "R8", "done during busy start", int'(done), 0);
    @(negedge clk);
    chk(done == 1'b1, "R8", "done", int'(done), 1);
    chk(err_flags == 4'b0110, "R8", "err_flags", int'(err_flags), 6);
    check_outs("R8");
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(done == 1'b0, "R8", "extra done", int'(done), 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    fork
      begin
        t_clean();
        t_single();
        t_pair();
        t_many();
        t_busy();
      end
      begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL R2 watchdog: actual hung expected done");
      end
    join_any
    disable fork;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule